// File: doc/BRIEF.md
# Line-Segmenting DMA Request Sequencer

This block takes one DMA transfer at a time from a requester. Each transfer is a start byte address, a byte count and a direction (load or store). The block splits the transfer into segments that never cross a cache line. It sends those segments one by one to a downstream memory controller. Only one segment is in flight at any time. The next segment is issued only after the controller acknowledges a store segment or returns line data for a load segment. When all bytes are covered, a one-cycle completion pulse goes back to the requester.

The first segment starts at the requested address and is clipped at the end of its line. Every later segment starts on a line boundary and covers a full line, or whatever bytes are left. Store data is read from the requester's buffer through a position/data port. It is shifted to its byte offset within the line. Load data is pulled out of the returned line and handed back with a position and a byte mask.

Top module: `dma_line_seq`

## Requirements
- R1: A request with `req_type` 0 (load) or 1 (store) that arrives while idle is accepted in the same cycle (`req_accept`). `busy` is high from the next cycle on.
- R2: A request that arrives while busy raises `req_full` in that cycle and is dropped. It never produces a segment, not even after the current transfer ends.
- R3: A request with a `req_type` code from 2 to 7 that arrives while idle raises `req_type_err`. It is not accepted, and the block stays idle.
- R4: The first segment goes to the start address. Its length is the request length if offset plus length fits in one line; otherwise it is the line size minus the offset. The offset is the start address modulo the line size. `seg_be` bit i marks line byte i, and the first segment sets the bits from the offset for its length.
- R5: Each later segment goes to the start address plus the bytes completed so far, which is line-aligned. Its length is the smaller of the line size and the bytes remaining, and its `seg_be` bits start at bit 0.
- R6: After a segment handshake (`seg_valid` and `seg_ready` both high), `seg_valid` stays low until a response has been taken. A segment waiting for `seg_ready` holds its address and length.
- R7: For stores, `src_rd_pos` equals the bytes completed so far, and `src_rd_data` byte 0 is the buffer byte at that position. `seg_data` byte (offset + k) carries `src_rd_data` byte k for every enabled byte. Byte k of any line-wide bus sits at bits 8k+7 down to 8k.
- R8: For a load data response, `dst_wr_valid` pulses in the same cycle and `dst_wr_pos` equals the bytes completed before that segment. `dst_wr_mask` has its low (segment length) bits set. `dst_wr_data` byte j is line byte (offset + j), where the offset is the start offset for the first segment and zero for later ones.
- R9: `done` pulses for one cycle, in the cycle after the response that covers the last byte, and `busy` is low in that same cycle.
- R10: A zero-length request issues no segment. `done` pulses two cycles after acceptance, in the cycle right after the one busy cycle.
- R11: A response while no segment is outstanding raises `rsp_err` in that cycle and has no other effect: no read data, no state change.
- R12: `seg_write` is 1 for store transfers and 0 for load transfers. `seg_line_addr` is `seg_addr` with its line-offset bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_type | input | 3 | Request kind: 0 load, 1 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_accept | output | 1 | Request taken this cycle |
| req_full | output | 1 | Request refused, transfer in progress |
| req_type_err | output | 1 | Request refused, illegal kind |
| busy | output | 1 | A transfer is active |
| done | output | 1 | Transfer completion pulse |
| src_rd_pos | output | LEN_W | Buffer byte position of store data needed |
| src_rd_data | input | 8*LINE_BYTES | Buffer bytes starting at `src_rd_pos` |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Controller takes the segment |
| seg_addr | output | ADDR_W | Segment byte address |
| seg_line_addr | output | ADDR_W | Segment line address |
| seg_write | output | 1 | 1 store, 0 load |
| seg_len | output | $clog2(LINE_BYTES)+1 | Segment byte count |
| seg_be | output | LINE_BYTES | Byte enables within the line |
| seg_data | output | 8*LINE_BYTES | Store data placed in line position |
| rsp_valid | input | 1 | Response strobe |
| rsp_is_data | input | 1 | 1 read data, 0 acknowledgement |
| rsp_data | input | 8*LINE_BYTES | Returned line |
| rsp_err | output | 1 | Response with nothing outstanding |
| dst_wr_valid | output | 1 | Load bytes ready for the requester buffer |
| dst_wr_pos | output | LEN_W | Buffer byte position of those bytes |
| dst_wr_mask | output | LINE_BYTES | Valid low bytes of `dst_wr_data` |
| dst_wr_data | output | 8*LINE_BYTES | Load bytes, first valid byte at byte 0 |

## Verification
Transfers are tried from several start points. A short transfer inside one line shows whether the head rule keeps the request length. An unaligned transfer that spans several lines and ends in a partial tail shows whether the head clip and the tail clip are kept apart. An aligned two-line store shows whether a start at offset zero is mistaken for a head clip, and a store one byte short of a boundary shows the one-byte head case. A transfer that exactly fills a line from a nonzero offset, and a full aligned line, probe the equality edge of the fit test. Back-pressure on `seg_ready`, a request poked in mid-transfer, illegal kinds, a zero-length request and a stray response each isolate one control path.

// File: rtl/dma_seg_pkg.sv
package dma_seg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } seq_state_e;

  localparam logic [2:0] KIND_LOAD  = 3'd0;
  localparam logic [2:0] KIND_STORE = 3'd1;

  function automatic logic kind_ok(input logic [2:0] kind);
    return (kind == KIND_LOAD) || (kind == KIND_STORE);
  endfunction

endpackage

// File: rtl/dma_seg_calc.sv
module dma_seg_calc #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic [LEN_W-1:0]              total_len,
  input  logic [LEN_W-1:0]              done_bytes,
  output logic [ADDR_W-1:0]             seg_addr,
  output logic [ADDR_W-1:0]             seg_line_addr,
  output logic [$clog2(LINE_BYTES)-1:0] seg_off,
  output logic [$clog2(LINE_BYTES):0]   seg_len,
  output logic [LINE_BYTES-1:0]         seg_be
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SEGL_W = OFF_W + 1;

  // head segment: whole request if it fits in the line, else up to the boundary
  function automatic logic [SEGL_W-1:0] head_len_f(input logic [OFF_W-1:0] off,
                                                   input logic [LEN_W-1:0] len);
    logic [LEN_W:0] reach;
    reach = {1'b0, len} + (LEN_W+1)'(off);
    if (reach <= (LEN_W+1)'(LINE_BYTES)) return SEGL_W'(len);
    else return SEGL_W'(LINE_BYTES) - SEGL_W'(off);
  endfunction

  // later segments: full line or what is left
  function automatic logic [SEGL_W-1:0] tail_len_f(input logic [LEN_W-1:0] rem);
    if (rem < LEN_W'(LINE_BYTES)) return SEGL_W'(rem);
    else return SEGL_W'(LINE_BYTES);
  endfunction

  function automatic logic [LINE_BYTES-1:0] span_mask_f(input logic [OFF_W-1:0] off,
                                                        input logic [SEGL_W-1:0] cnt);
    logic [LINE_BYTES-1:0] m;
    for (int i = 0; i < LINE_BYTES; i++)
      m[i] = (i >= int'(off)) && (i < int'(off) + int'(cnt));
    return m;
  endfunction

  logic is_head;

  always_comb begin
    is_head       = (done_bytes == '0);
    seg_addr      = start_addr + ADDR_W'(done_bytes);
    seg_line_addr = {seg_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    seg_off       = is_head ? start_addr[OFF_W-1:0] : '0;
    seg_len       = is_head ? head_len_f(start_addr[OFF_W-1:0], total_len)
                            : tail_len_f(total_len - done_bytes);
    seg_be        = span_mask_f(seg_off, seg_len);
  end

endmodule

// File: rtl/dma_seg_rdalign.sv
module dma_seg_rdalign #(
  parameter int LINE_BYTES = 16
) (
  input  logic [8*LINE_BYTES-1:0]       line_data,
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [$clog2(LINE_BYTES):0]   cnt,
  output logic [8*LINE_BYTES-1:0]       out_data,
  output logic [LINE_BYTES-1:0]         out_mask
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SEGL_W = OFF_W + 1;

  function automatic logic [LINE_BYTES-1:0] low_mask_f(input logic [SEGL_W-1:0] n);
    logic [LINE_BYTES-1:0] m;
    for (int i = 0; i < LINE_BYTES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  always_comb begin
    out_data = line_data >> {off, 3'b000};
    out_mask = low_mask_f(cnt);
  end

endmodule

// File: rtl/dma_seg_ctrl.sv
module dma_seg_ctrl
  import dma_seg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [2:0]                    req_type,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  input  logic                          seg_ready,
  input  logic [$clog2(LINE_BYTES):0]   seg_len,
  input  logic                          rsp_valid,
  output logic [ADDR_W-1:0]             start_addr,
  output logic [LEN_W-1:0]              total_len,
  output logic [LEN_W-1:0]              issued,
  output logic [LEN_W-1:0]              completed,
  output logic                          is_write,
  output logic                          req_accept,
  output logic                          req_full,
  output logic                          req_type_err,
  output logic                          busy,
  output logic                          seg_valid,
  output logic                          rsp_take,
  output logic                          rsp_err,
  output logic                          done
);
  seq_state_e state;
  logic       idle;

  always_comb begin
    idle         = (state == ST_IDLE);
    busy         = !idle;
    req_accept   = req_valid && idle && kind_ok(req_type);
    req_type_err = req_valid && idle && !kind_ok(req_type);
    req_full     = req_valid && !idle;
    seg_valid    = (state == ST_ISSUE);
    rsp_take     = rsp_valid && (state == ST_WAIT);
    rsp_err      = rsp_valid && (state != ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      start_addr <= '0;
      total_len  <= '0;
      issued     <= '0;
      completed  <= '0;
      is_write   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_accept) begin
            start_addr <= req_addr;
            total_len  <= req_len;
            is_write   <= (req_type == KIND_STORE);
            issued     <= '0;
            completed  <= '0;
            state      <= (req_len == '0) ? ST_FINISH : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (seg_ready) begin
            issued <= issued + LEN_W'(seg_len);
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            completed <= issued;
            if (issued == total_len) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [2:0]                    req_type,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  output logic                          req_accept,
  output logic                          req_full,
  output logic                          req_type_err,
  output logic                          busy,
  output logic                          done,
  output logic [LEN_W-1:0]              src_rd_pos,
  input  logic [8*LINE_BYTES-1:0]       src_rd_data,
  output logic                          seg_valid,
  input  logic                          seg_ready,
  output logic [ADDR_W-1:0]             seg_addr,
  output logic [ADDR_W-1:0]             seg_line_addr,
  output logic                          seg_write,
  output logic [$clog2(LINE_BYTES):0]   seg_len,
  output logic [LINE_BYTES-1:0]         seg_be,
  output logic [8*LINE_BYTES-1:0]       seg_data,
  input  logic                          rsp_valid,
  input  logic                          rsp_is_data,
  input  logic [8*LINE_BYTES-1:0]       rsp_data,
  output logic                          rsp_err,
  output logic                          dst_wr_valid,
  output logic [LEN_W-1:0]              dst_wr_pos,
  output logic [LINE_BYTES-1:0]         dst_wr_mask,
  output logic [8*LINE_BYTES-1:0]       dst_wr_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SEGL_W = OFF_W + 1;

  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  total_len;
  logic [LEN_W-1:0]  issued;
  logic [LEN_W-1:0]  completed;
  logic              is_write;
  logic              rsp_take;
  logic [OFF_W-1:0]  seg_off;
  logic [SEGL_W-1:0] inflight_cnt;

  dma_seg_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_len(req_len),
    .seg_ready(seg_ready), .seg_len(seg_len), .rsp_valid(rsp_valid),
    .start_addr(start_addr), .total_len(total_len), .issued(issued),
    .completed(completed), .is_write(is_write),
    .req_accept(req_accept), .req_full(req_full), .req_type_err(req_type_err),
    .busy(busy), .seg_valid(seg_valid), .rsp_take(rsp_take), .rsp_err(rsp_err),
    .done(done)
  );

  dma_seg_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .start_addr(start_addr), .total_len(total_len), .done_bytes(completed),
    .seg_addr(seg_addr), .seg_line_addr(seg_line_addr), .seg_off(seg_off),
    .seg_len(seg_len), .seg_be(seg_be)
  );

  // bytes handed out but not yet covered by a response
  assign inflight_cnt = SEGL_W'(issued - completed);

  dma_seg_rdalign #(
    .LINE_BYTES(LINE_BYTES)
  ) u_rdalign (
    .line_data(rsp_data), .off(seg_off), .cnt(inflight_cnt),
    .out_data(dst_wr_data), .out_mask(dst_wr_mask)
  );

  always_comb begin
    seg_write    = is_write;
    src_rd_pos   = completed;
    seg_data     = src_rd_data << {seg_off, 3'b000};
    dst_wr_valid = rsp_take && !is_write && rsp_is_data;
    dst_wr_pos   = completed;
  end

endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_accept,
  input logic [LEN_W-1:0]            req_len,
  input logic                        busy,
  input logic                        done,
  input logic                        seg_valid,
  input logic                        seg_ready,
  input logic [ADDR_W-1:0]           seg_addr,
  input logic [$clog2(LINE_BYTES):0] seg_len,
  input logic [LINE_BYTES-1:0]       seg_be,
  input logic                        rsp_err
);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> busy);

  // R6
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> !seg_valid);

  // R6
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  // R4
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ($countones(seg_be) == int'(seg_len)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && req_len == '0) |=> (!seg_valid ##1 done));

  // R11
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !busy && !req_accept) |=> !seg_valid);

endmodule

bind dma_line_seq dma_line_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .req_len(req_len),
  .busy(busy), .done(done), .seg_valid(seg_valid), .seg_ready(seg_ready),
  .seg_addr(seg_addr), .seg_len(seg_len), .seg_be(seg_be), .rsp_err(rsp_err)
);

// File: tb/dma_line_seq_bench.sv
`timescale 1ns/1ps
module dma_line_seq_bench;
  localparam int AW = 16;
  localparam int LW = 12;
  localparam int LB = 16;
  localparam int DW = 8*LB;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_type = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic req_accept, req_full, req_type_err, busy, done;
  logic [LW-1:0] src_rd_pos;
  logic [DW-1:0] src_rd_data;
  logic seg_valid;
  logic seg_ready = 0;
  logic [AW-1:0] seg_addr, seg_line_addr;
  logic seg_write;
  logic [$clog2(LB):0] seg_len;
  logic [LB-1:0] seg_be;
  logic [DW-1:0] seg_data;
  logic rsp_valid = 0;
  logic rsp_is_data = 0;
  logic [DW-1:0] rsp_data = 0;
  logic rsp_err, dst_wr_valid;
  logic [LW-1:0] dst_wr_pos;
  logic [LB-1:0] dst_wr_mask;
  logic [DW-1:0] dst_wr_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_line_seq #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB)) u_dma_line_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_len(req_len), .req_accept(req_accept),
    .req_full(req_full), .req_type_err(req_type_err), .busy(busy), .done(done),
    .src_rd_pos(src_rd_pos), .src_rd_data(src_rd_data), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_line_addr(seg_line_addr),
    .seg_write(seg_write), .seg_len(seg_len), .seg_be(seg_be), .seg_data(seg_data),
    .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .dst_wr_valid(dst_wr_valid), .dst_wr_pos(dst_wr_pos),
    .dst_wr_mask(dst_wr_mask), .dst_wr_data(dst_wr_data)
  );

  function automatic logic [7:0] src_byte(input int p);
    return 8'(p * 7 + 3);
  endfunction

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 3 + 1) ^ 'h5A);
  endfunction

  // requester buffer model: byte k is the buffer byte at src_rd_pos + k
  always_comb
    for (int k = 0; k < LB; k++) src_rd_data[8*k +: 8] = src_byte(int'(src_rd_pos) + k);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [2:0] kind, input int start, input int len);
    @(negedge clk);
    req_valid = 1; req_type = kind; req_addr = AW'(start); req_len = LW'(len);
    #1;
  endtask

  task automatic run_xfer(input int start, input int len, input bit wr,
                          input bit stall, input bit poke);
    int done_b;
    int off, cnt, addr, line;
    bit first;
    bit ok;
    logic [LB-1:0] exp_be, exp_mask;
    send_req(wr ? 3'd1 : 3'd0, start, len);
    chk(req_accept == 1, "R1", "req_accept", DW'(req_accept), 1);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R1", "busy after accept", DW'(busy), 1);
    done_b = 0;
    first = 1;
    while (done_b < len) begin
      off  = first ? (start % LB) : 0;
      cnt  = first ? ((off + len <= LB) ? len : LB - off)
                   : ((len - done_b < LB) ? len - done_b : LB);
      addr = start + done_b;
      line = addr - (addr % LB);
      for (int i = 0; i < LB; i++) exp_be[i] = (i >= off) && (i < off + cnt);
      chk(seg_valid == 1, first ? "R4" : "R5", "seg_valid", DW'(seg_valid), 1);
      chk(seg_addr == AW'(addr), first ? "R4" : "R5", "seg_addr", DW'(seg_addr), DW'(addr));
      chk(int'(seg_len) == cnt, first ? "R4" : "R5", "seg_len", DW'(seg_len), DW'(cnt));
      chk(seg_be == exp_be, first ? "R4" : "R5", "seg_be", DW'(seg_be), DW'(exp_be));
      chk(seg_line_addr == AW'(line), "R12", "seg_line_addr", DW'(seg_line_addr), DW'(line));
      chk(seg_write == wr, "R12", "seg_write", DW'(seg_write), DW'(wr));
      if (wr) begin
        chk(int'(src_rd_pos) == done_b, "R7", "src_rd_pos", DW'(src_rd_pos), DW'(done_b));
        ok = 1;
        for (int k = off; k < off + cnt; k++)
          if (seg_data[8*k +: 8] != src_byte(done_b + k - off)) ok = 0;
        chk(ok, "R7", "seg_data bytes", seg_data, 0);
      end
      if (stall) begin
        @(negedge clk);
        chk(seg_valid == 1 && seg_addr == AW'(addr), "R6", "held under stall",
            DW'(seg_addr), DW'(addr));
      end
      seg_ready = 1;
      @(negedge clk);
      seg_ready = 0;
      chk(seg_valid == 0, "R6", "no second segment", DW'(seg_valid), 0);
      if (poke && first) begin
        req_valid = 1; req_type = 3'd0; req_addr = 16'h0777; req_len = 4;
        #1;
        chk(req_full == 1 && req_accept == 0, "R2", "full while busy",
            DW'({req_full, req_accept}), 2);
        @(negedge clk);
        req_valid = 0;
      end
      @(negedge clk);
      chk(seg_valid == 0, "R6", "still waiting", DW'(seg_valid), 0);
      rsp_valid = 1;
      rsp_is_data = !wr;
      for (int k = 0; k < LB; k++) rsp_data[8*k +: 8] = mem_byte(line + k);
      #1;
      if (!wr) begin
        for (int i = 0; i < LB; i++) exp_mask[i] = (i < cnt);
        chk(dst_wr_valid == 1, "R8", "dst_wr_valid", DW'(dst_wr_valid), 1);
        chk(int'(dst_wr_pos) == done_b, "R8", "dst_wr_pos", DW'(dst_wr_pos), DW'(done_b));
        chk(dst_wr_mask == exp_mask, "R8", "dst_wr_mask", DW'(dst_wr_mask), DW'(exp_mask));
        ok = 1;
        for (int j = 0; j < cnt; j++)
          if (dst_wr_data[8*j +: 8] != mem_byte(addr + j)) ok = 0;
        chk(ok, "R8", "dst_wr_data bytes", dst_wr_data, 0);
      end else begin
        chk(dst_wr_valid == 0, "R8", "no read data on store", DW'(dst_wr_valid), 0);
      end
      @(negedge clk);
      rsp_valid = 0;
      done_b += cnt;
      first = 0;
      if (done_b == len)
        chk(done == 1 && busy == 0, "R9", "completion", DW'({done, busy}), 2);
      else
        chk(done == 0 && busy == 1, "R9", "no early completion", DW'({done, busy}), 1);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(seg_valid == 0 && busy == 0, "R2", "refused request not queued",
          DW'({seg_valid, busy}), 0);
    end
  endtask

  task automatic t_reset;
    chk(busy == 0 && seg_valid == 0 && done == 0, "R1", "reset state",
        DW'({busy, seg_valid, done}), 0);
  endtask

  task automatic t_zero_len;
    send_req(3'd0, 16'h0500, 0);
    chk(req_accept == 1, "R10", "zero accept", DW'(req_accept), 1);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1 && seg_valid == 0, "R10", "busy, no segment", DW'({busy, seg_valid}), 2);
    @(negedge clk);
    chk(done == 1 && busy == 0 && seg_valid == 0, "R10", "zero done",
        DW'({done, busy, seg_valid}), 4);
    @(negedge clk);
    chk(done == 0, "R10", "done one cycle", DW'(done), 0);
  endtask

  task automatic t_bad_kind(input logic [2:0] kind);
    send_req(kind, 16'h0600, 8);
    chk(req_type_err == 1 && req_accept == 0, "R3", "illegal kind",
        DW'({req_type_err, req_accept}), 2);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 0 && seg_valid == 0, "R3", "stays idle", DW'({busy, seg_valid}), 0);
  endtask

  task automatic t_stray_rsp;
    @(negedge clk);
    rsp_valid = 1; rsp_is_data = 1;
    #1;
    chk(rsp_err == 1 && dst_wr_valid == 0, "R11", "stray response",
        DW'({rsp_err, dst_wr_valid}), 2);
    @(negedge clk);
    rsp_valid = 0;
    chk(busy == 0 && seg_valid == 0 && done == 0, "R11", "no effect",
        DW'({busy, seg_valid, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_xfer(16'h0103, 5, 0, 1, 0);
    run_xfer(16'h010A, 40, 0, 0, 1);
    run_xfer(16'h0200, 32, 1, 0, 0);
    run_xfer(16'h020F, 3, 1, 1, 0);
    run_xfer(16'h03F1, 15, 1, 0, 0);
    run_xfer(16'h0400, 16, 0, 0, 0);
    t_zero_len();
    t_bad_kind(3'd3);
    t_bad_kind(3'd6);
    t_stray_rsp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule